// File: doc/BRIEF.md
# Paged Address Mapper with Page Status Tracking

This block turns a 22-bit CPU address into a 22-bit physical address. It looks up a 1024-entry map RAM held inside the block, with one entry for each 4 KB page. The upper ten address bits select the entry. The entry supplies a physical frame number, and the low twelve bits pass through unchanged as the offset. Translation is combinational from the CPU access inputs and the current map contents.

Each entry also holds a write-enable flag and a two-bit page status. The mapper advances that status on the clock edge that closes an access: an untouched page becomes accessed, and a written page becomes dirty. Pages marked absent raise a page fault. Writes to pages without write permission raise a protection fault. No status change is made in a level-7 interrupt acknowledge cycle or in a cycle that ends in a bus error.

A byte-wide programming port loads the map and reads it back. It writes synchronously and reads combinationally.

Top module: `page_mapper`

## Requirements
- R1: For a permitted access, phys_valid is 1 and phys_addr equals entry bits 9..0 placed at physical bits 21..12, with cpu_addr bits 11..0 as physical bits 11..0. The entry is the one indexed by cpu_addr bits 21..12.
- R2: Map entry n sits at programming byte address 2n, which holds entry bits 15..8, and at 2n+1, which holds entry bits 7..0. A byte written with prog_we is stored on the clock edge. prog_rdata shows the addressed byte without delay.
- R3: Entry bits 12..10 are stored and read back, have no effect on translation or faults, and are kept when the mapper updates the status.
- R4: After reset every entry reads as zero, so every access raises a page fault.
- R5: The page status is entry bits 14 (upper) and 13 (lower), where 00 means absent. An access to an absent page sets fault_page, clears phys_valid and drives phys_addr to zero.
- R6: An access never modifies an entry whose status is 00.
- R7: A permitted read changes status 01 to 10 and leaves 10 and 11 as they are.
- R8: A permitted write, meaning entry bit 15 is 1 and the page is present, sets the status to 11.
- R9: A write to a present page whose entry bit 15 is 0 sets fault_wp, clears phys_valid and leaves the entry unchanged.
- R10: When cpu_ipl7 or cpu_berr is high, translation is still given but no status update is made.
- R11: When a programming write targets the entry being accessed in the same cycle, the programming write wins and no status update is applied to that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the map |
| cpu_valid | input | 1 | CPU access in this cycle |
| cpu_addr | input | 22 | CPU address |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_ipl7 | input | 1 | Cycle is a level-7 interrupt acknowledge |
| cpu_berr | input | 1 | Cycle ends in a bus error |
| phys_addr | output | 22 | Translated address, zero when not valid |
| phys_valid | output | 1 | Translation permitted |
| fault_page | output | 1 | Access to an absent page |
| fault_wp | output | 1 | Write to a write-protected page |
| prog_we | input | 1 | Programming byte write strobe |
| prog_addr | input | 11 | Programming byte address |
| prog_wdata | input | 8 | Programming write byte |
| prog_rdata | output | 8 | Programming read byte |

## Verification
The bench looks for the corner cases where the status logic is easy to get wrong.

- An access to an absent page must not touch its entry. A design that sets the accessed bit without checking presence would turn 00 into 10.
- A read of a page in status 01 must give 10. A design that ORs in the accessed bit would give 11 and mark a clean page dirty.
- Interrupt-acknowledge cycles, bus-error cycles and write-protect faults must leave the entry as it was. A design that ignored those qualifiers would change the status bits when it should not.
- When a programming write and a status write-back hit the same entry in one cycle, the bench checks that the programmed byte is the one that survives.

// File: rtl/page_mapper.sv
module page_mapper #(
  parameter int VA_W   = 22,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [VA_W-1:0]   cpu_addr,
  input  logic              cpu_write,
  input  logic              cpu_ipl7,
  input  logic              cpu_berr,
  output logic [VA_W-1:0]   phys_addr,
  output logic              phys_valid,
  output logic              fault_page,
  output logic              fault_wp,
  input  logic              prog_we,
  input  logic [VA_W-PAGE_W:0] prog_addr,
  input  logic [7:0]        prog_wdata,
  output logic [7:0]        prog_rdata
);
  localparam int IDX_W   = VA_W - PAGE_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [15:0] map_q [ENTRIES];

  logic [IDX_W-1:0] page, prog_idx;
  logic [15:0]      cur;
  logic [1:0]       st, new_st;
  logic             present, wr_ok, prog_hit, upd;

  assign page     = cpu_addr[VA_W-1:PAGE_W];
  assign cur      = map_q[page];
  assign st       = cur[14:13];
  assign present  = |st;
  assign wr_ok    = cur[15];
  assign prog_idx = prog_addr[IDX_W:1];
  assign prog_hit = prog_we && (prog_idx == page);

  assign fault_page = cpu_valid && !present;
  assign fault_wp   = cpu_valid && present && cpu_write && !wr_ok;
  assign phys_valid = cpu_valid && present && !(cpu_write && !wr_ok);
  assign phys_addr  = phys_valid ? {cur[IDX_W-1:0], cpu_addr[PAGE_W-1:0]} : '0;

  assign upd    = phys_valid && !cpu_ipl7 && !cpu_berr && !prog_hit;
  assign new_st = cpu_write ? 2'b11 : {1'b1, st[1] & st[0]};

  assign prog_rdata = prog_addr[0] ? map_q[prog_idx][7:0] : map_q[prog_idx][15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) map_q[i] <= '0;
    end else begin
      if (prog_we) begin
        if (prog_addr[0]) map_q[prog_idx][7:0]  <= prog_wdata;
        else              map_q[prog_idx][15:8] <= prog_wdata;
      end
      if (upd) map_q[page][14:13] <= new_st;
    end
  end

  AST_ABSENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && st == 2'b00 && !prog_hit) |=> map_q[$past(page)] == $past(cur)); // R6

  AST_WP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_wp && !prog_hit) |=> map_q[$past(page)] == $past(cur)); // R9

  AST_QUAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && (cpu_ipl7 || cpu_berr) && !prog_hit) |=> map_q[$past(page)] == $past(cur)); // R10

  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && wr_ok && present && !cpu_ipl7 && !cpu_berr && !prog_hit)
      |=> map_q[$past(page)][14:13] == 2'b11); // R8

  AST_PROG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> prog_rdata == $past(prog_wdata) || prog_addr != $past(prog_addr)); // R2
endmodule

// File: tb/sim_page_mapper.sv
module sim_page_mapper;
  logic        clk = 0, rst_n = 0;
  logic        cpu_valid = 0, cpu_write = 0, cpu_ipl7 = 0, cpu_berr = 0;
  logic [21:0] cpu_addr = '0;
  logic [21:0] phys_addr;
  logic        phys_valid, fault_page, fault_wp;
  logic        prog_we = 0;
  logic [10:0] prog_addr = '0;
  logic [7:0]  prog_wdata = '0, prog_rdata;

  int checks = 0, fails = 0;
  logic [21:0] s_pa;
  logic        s_pv, s_fp, s_fw;

  always #5 clk = ~clk;

  page_mapper u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prog_wr(input int idx, input logic [15:0] v);
    @(negedge clk); prog_we = 1; prog_addr = 11'(idx * 2);     prog_wdata = v[15:8];
    @(negedge clk);              prog_addr = 11'(idx * 2 + 1); prog_wdata = v[7:0];
    @(negedge clk); prog_we = 0;
  endtask

  task automatic prog_rd(input int idx, output logic [15:0] v);
    @(negedge clk); prog_addr = 11'(idx * 2);     #1 v[15:8] = prog_rdata;
                    prog_addr = 11'(idx * 2 + 1); #1 v[7:0]  = prog_rdata;
  endtask

  task automatic cpu_acc(input int idx, input logic [11:0] off, input bit wr, input bit i7, input bit be);
    @(negedge clk);
    cpu_valid = 1; cpu_addr = {10'(idx), off}; cpu_write = wr; cpu_ipl7 = i7; cpu_berr = be;
    #1 s_pa = phys_addr; s_pv = phys_valid; s_fp = fault_page; s_fw = fault_wp;
    @(negedge clk);
    cpu_valid = 0; cpu_write = 0; cpu_ipl7 = 0; cpu_berr = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    prog_rd(5, v);
    check(v == 16'h0, "R4 entry zero after reset", v, 0);
    cpu_acc(5, 12'h010, 0, 0, 0);
    check(s_fp && !s_pv, "R4 fault after reset", {s_fp, s_pv}, 2'b10);
  endtask

  task automatic t_layout;
    logic [7:0] hi, lo;
    prog_wr(3, 16'hA5C3);
    @(negedge clk); prog_addr = 11'd6; #1 hi = prog_rdata;
                    prog_addr = 11'd7; #1 lo = prog_rdata;
    check(hi == 8'hA5, "R2 high byte at 2n", hi, 8'hA5);
    check(lo == 8'hC3, "R2 low byte at 2n+1", lo, 8'hC3);
  endtask

  task automatic t_translate;
    logic [15:0] v;
    prog_wr(7, 16'hA2AB);
    cpu_acc(7, 12'h123, 0, 0, 0);
    check(s_pv && s_pa == {10'h2AB, 12'h123}, "R1 translated read", s_pa, {10'h2AB, 12'h123});
    prog_rd(7, v);
    check(v == 16'hC2AB, "R7 status 01 to 10 on read", v, 16'hC2AB);
    cpu_acc(7, 12'hFFF, 0, 0, 0);
    prog_rd(7, v);
    check(v == 16'hC2AB, "R7 status 10 kept on read", v, 16'hC2AB);
    cpu_acc(7, 12'h000, 1, 0, 0);
    check(s_pv && s_pa == {10'h2AB, 12'h000}, "R1 translated write", s_pa, {10'h2AB, 12'h000});
    prog_rd(7, v);
    check(v == 16'hE2AB, "R8 write sets dirty", v, 16'hE2AB);
    cpu_acc(7, 12'h004, 0, 0, 0);
    prog_rd(7, v);
    check(v == 16'hE2AB, "R7 status 11 kept on read", v, 16'hE2AB);
  endtask

  task automatic t_unused;
    logic [15:0] v;
    prog_wr(9, 16'h3C11);
    cpu_acc(9, 12'h3A0, 0, 0, 0);
    check(s_pv && !s_fp && s_pa == {10'h011, 12'h3A0}, "R3 unused bits no effect", s_pa, {10'h011, 12'h3A0});
    prog_rd(9, v);
    check(v == 16'h5C11, "R3 unused bits kept on update", v, 16'h5C11);
  endtask

  task automatic t_absent;
    logic [15:0] v;
    prog_wr(12, 16'h8155);
    cpu_acc(12, 12'h055, 1, 0, 0);
    check(s_fp && !s_pv && s_pa == 0 && !s_fw, "R5 absent page fault", {s_fp, s_pv, s_fw}, 3'b100);
    prog_rd(12, v);
    check(v == 16'h8155, "R6 absent entry untouched", v, 16'h8155);
  endtask

  task automatic t_wp;
    logic [15:0] v;
    prog_wr(20, 16'h2033);
    cpu_acc(20, 12'h100, 1, 0, 0);
    check(s_fw && !s_pv && !s_fp, "R9 write-protect fault", {s_fw, s_pv, s_fp}, 3'b100);
    prog_rd(20, v);
    check(v == 16'h2033, "R9 entry unchanged", v, 16'h2033);
  endtask

  task automatic t_suppress;
    logic [15:0] v;
    prog_wr(30, 16'hA044);
    cpu_acc(30, 12'h222, 0, 1, 0);
    check(s_pv && s_pa == {10'h044, 12'h222}, "R10 translation during ipl7", s_pa, {10'h044, 12'h222});
    prog_rd(30, v);
    check(v == 16'hA044, "R10 ipl7 no update", v, 16'hA044);
    cpu_acc(30, 12'h222, 1, 0, 1);
    prog_rd(30, v);
    check(v == 16'hA044, "R10 berr no update", v, 16'hA044);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    prog_wr(40, 16'hA001);
    @(negedge clk);
    cpu_valid = 1; cpu_addr = {10'd40, 12'h0}; cpu_write = 0;
    prog_we = 1; prog_addr = 11'd80; prog_wdata = 8'h80;
    @(negedge clk);
    cpu_valid = 0; prog_we = 0;
    prog_rd(40, v);
    check(v == 16'h8001, "R11 programming write wins", v, 16'h8001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    t_translate();
    t_unused();
    t_absent();
    t_wp();
    t_suppress();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule